// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Lock

This block keeps the single reservation flag used by word-sized load-reserved (LR) and store-conditional (SC) operations. The execute stage presents each data access as a request tagged normal, LR or SC, together with a store flag and the instruction's ordering bits. A separate trap pulse reports interrupts and access faults. The block answers with a write-permit strobe for the bus and, for every SC, a result word for the destination register.

The reservation is one flag and is not tied to an address. An LR that completes without a trap sets it. Any other accepted access clears it, and so does any trap. Every SC clears it, whether the SC succeeds or fails. An SC is allowed to write memory only while the flag is set, and its result is 0 on success and 1 on failure.

Requests use a valid/ready handshake. An access is accepted on a clock edge where `req_valid` and `req_ready` are both high. The SC result leaves through a one-entry valid/ready slot. `req_ready` is low only while a result is pending and `res_ready` is low, so a stalled consumer holds back the next request. A pending result and its data stay unchanged until they are taken.

Top module: `lrsc_reservation`

## Requirements
- R1: After reset the reservation is clear, `res_valid` is 0, `req_ready` is 1 and `mem_we` is 0.
- R2: An accepted LR (`req_kind`=1) with `trap` low sets the reservation and does not raise `mem_we`, whatever `req_write` is.
- R3: An accepted SC (`req_kind`=2) while the reservation is set and `trap` is low raises `mem_we` in its accept cycle, and one cycle later presents `res_valid`=1 with `res_data`=0.
- R4: An accepted SC while the reservation is clear keeps `mem_we` low, and one cycle later presents `res_data`=1.
- R5: Every accepted SC clears the reservation, so a second SC right after a successful one fails.
- R6: An accepted normal access (`req_kind`=0, or the unused code 3) clears the reservation. `mem_we` for it equals `req_write`.
- R7: `trap` high clears the reservation, with or without a request. An SC accepted in a trap cycle fails: no write, result 1.
- R8: An LR accepted in the same cycle as `trap` leaves the reservation clear.
- R9: The ordering bits `req_order` have no effect on the write permit, the result or the reservation.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and `res_data` hold, `req_ready` is 0, and no request is accepted.
- R11: When `req_valid` is 0 the request fields have no effect on the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Data-access request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 2 | 0 normal, 1 LR, 2 SC, 3 treated as normal |
| req_write | input | 1 | Normal access is a store |
| req_order | input | 2 | Ordering bits, ignored |
| trap | input | 1 | Trap taken this cycle |
| mem_we | output | 1 | Memory write permitted for the accepted access |
| res_valid | output | 1 | SC result available |
| res_ready | input | 1 | Consumer takes the SC result |
| res_data | output | 32 | SC result: 0 success, 1 failure |

## Verification
The hardest cases to reach are the ones where two events land in the same cycle: an LR that faults, and an SC that meets a trap. In both, the effect on the reservation only shows up later, through the outcome of a following SC. The stimulus table places the trap in the same vector as the LR or SC, then follows it with a probing SC. A directed sequence stalls `res_ready` after a successful SC while another SC is offered. This checks that nothing is accepted and the held result stays unchanged until the stall is released.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    ACC_NORMAL = 2'd0,
    ACC_LR     = 2'd1,
    ACC_SC     = 2'd2,
    ACC_RSVD   = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/lrsc_lock_reg.sv
module lrsc_lock_reg
  import lrsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire,
  input  acc_kind_e kind,
  input  logic      trap,
  output logic      lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)          lock_q <= 1'b0;
    else if (trap)       lock_q <= 1'b0;
    else if (fire)       lock_q <= (kind == ACC_LR);
  end

  // R7
  trap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !lock_q);

  // R5
  sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == ACC_SC) |=> !lock_q);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !trap) |=> $stable(lock_q));
endmodule

// File: rtl/lrsc_result_slot.sv
module lrsc_result_slot #(
  parameter int RES_W     = 32,
  parameter int FAIL_CODE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             failed,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);
  localparam logic [RES_W-1:0] FAIL_WORD = RES_W'(FAIL_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_data  <= failed ? FAIL_WORD : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
endmodule

// File: rtl/lrsc_reservation.sv
module lrsc_reservation
  import lrsc_pkg::*;
#(
  parameter int RES_W     = 32,
  parameter int FAIL_CODE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic             req_write,
  input  logic [1:0]       req_order,
  input  logic             trap,
  output logic             mem_we,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [RES_W-1:0] res_data
);
  acc_kind_e kind;
  logic      fire, is_sc, is_norm, lock_q, sc_pass;
  logic [1:0] order_unused;

  assign kind         = acc_kind_e'(req_kind);
  assign order_unused = req_order;
  assign req_ready    = !res_valid || res_ready;
  assign fire         = req_valid && req_ready;
  assign is_sc        = (kind == ACC_SC);
  assign is_norm      = (kind == ACC_NORMAL) || (kind == ACC_RSVD);
  assign sc_pass      = lock_q && !trap;

  always_comb begin
    mem_we = 1'b0;
    if (fire && !trap) begin
      if (is_sc)        mem_we = lock_q;
      else if (is_norm) mem_we = req_write;
    end
  end

  lrsc_lock_reg u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .kind   (kind),
    .trap   (trap),
    .lock_q (lock_q)
  );

  lrsc_result_slot #(.RES_W(RES_W), .FAIL_CODE(FAIL_CODE)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire && is_sc),
    .failed    (!sc_pass),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  // R3
  sc_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_sc) |=> (res_valid && ((res_data == '0) == $past(mem_we))));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> (!req_ready && !mem_we));

  // R2
  lr_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == ACC_LR) |-> !mem_we);
endmodule

// File: tb/lrsc_reservation_bench.sv
module lrsc_reservation_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, trap = 1'b0, res_ready = 1'b1;
  logic [1:0]  req_kind = 2'd0, req_order = 2'd0;
  logic        req_ready, mem_we, res_valid;
  logic [31:0] res_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lrsc_reservation u_lrsc_reservation (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_write(req_write), .req_order(req_order),
    .trap(trap), .mem_we(mem_we), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data)
  );

  // rs: 0 no result expected, 2 result 0, 3 result 1
  typedef struct packed {
    logic v; logic [1:0] k; logic w; logic [1:0] o; logic t; logic we; logic [1:0] rs;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1,2,0,0,0,0,3},  // R4 SC with no reservation
    '{1,1,1,0,0,0,0},  // R2 LR, write flag ignored
    '{1,2,0,0,0,1,2},  // R3 SC succeeds
    '{1,2,0,0,0,0,3},  // R5 second SC fails
    '{1,1,0,0,0,0,0},
    '{0,0,0,0,1,0,0},  // R7 trap alone
    '{1,2,0,0,0,0,3},  // R7 probe
    '{1,1,0,0,0,0,0},
    '{1,0,0,0,0,0,0},  // R6 normal load
    '{1,2,0,0,0,0,3},  // R6 probe
    '{1,1,0,0,0,0,0},
    '{1,0,1,0,0,1,0},  // R6 normal store writes
    '{1,2,0,0,0,0,3},  // R6 probe
    '{1,1,0,0,1,0,0},  // R8 LR faults
    '{1,2,0,0,0,0,3},  // R8 probe
    '{1,1,0,3,0,0,0},  // R9 ordering bits set
    '{1,2,0,3,0,1,2},  // R9 SC succeeds
    '{1,1,0,0,0,0,0},
    '{0,2,1,0,0,0,0},  // R11 invalid request
    '{1,2,0,0,0,1,2},  // R11 probe
    '{1,1,0,0,0,0,0},
    '{1,2,0,0,1,0,3}   // R7 SC in trap cycle
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 1);
    chk(res_valid === 1'b0, "R1 res_valid", 32'(res_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: reservation clear -> SC fails
    req_valid = 1; req_kind = 2;
    #1 chk(mem_we === 1'b0, "R1 mem_we", 32'(mem_we), 0);
    @(posedge clk); #1;
    chk(res_valid && res_data == 1, "R1 result", res_data, 1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = VEC[i].v; req_kind = VEC[i].k; req_write = VEC[i].w;
      req_order = VEC[i].o; trap = VEC[i].t; res_ready = 1'b1;
      #1 chk(mem_we === VEC[i].we, $sformatf("vec%0d mem_we", i), 32'(mem_we), 32'(VEC[i].we));
      @(posedge clk); #1;
      if (VEC[i].rs == 0)
        chk(res_valid === 1'b0, $sformatf("vec%0d res_valid", i), 32'(res_valid), 0);
      else
        chk(res_valid === 1'b1 && res_data == 32'(VEC[i].rs[0]),
            $sformatf("vec%0d result", i), res_data, 32'(VEC[i].rs[0]));
    end

    // R10 back-pressure
    @(negedge clk); req_valid = 1; req_kind = 1; trap = 0; req_order = 0;
    @(negedge clk); req_kind = 2; res_ready = 0;
    @(posedge clk); #1;
    chk(res_valid && res_data == 0, "R10 stalled result", res_data, 0);
    chk(req_ready === 1'b0, "R10 req_ready low", 32'(req_ready), 0);
    @(negedge clk); req_kind = 0; req_write = 1;
    #1 chk(mem_we === 1'b0, "R10 no accept", 32'(mem_we), 0);
    @(posedge clk); #1;
    chk(res_valid && res_data == 0, "R10 held", res_data, 0);
    @(negedge clk); req_kind = 2; req_write = 0; res_ready = 1;
    #1 chk(req_ready === 1'b1 && mem_we === 1'b0, "R10 release SC fails", 32'(mem_we), 0);
    @(posedge clk); #1;
    chk(res_valid && res_data == 1, "R10 new result", res_data, 1);
    @(negedge clk); req_valid = 0;
    @(posedge clk); #1;
    chk(res_valid === 1'b0, "R10 drained", 32'(res_valid), 0);

    summary();
    $finish;
  end
endmodule